// File: doc/BRIEF.md
# Trigger-Accept Event Buffer

This block keeps a running history of one data word per clock in a dual-port RAM used as a circular buffer. The write side never stops: every clock edge stores the word on `wr_data` and advances the write pointer. When a level-1 accept arrives, the block freezes a read pointer for that event. The pointer sits a programmable number of words behind the write pointer. The event is a fixed window of `WIN_WORDS` consecutive words starting at that frozen pointer.

Accepts wait in a small in-order queue. A serialiser takes them one at a time and ships each event as a serial frame. A frame is a two-bit start marker, a two-bit event number and then the window words, most significant bit first. A frame may begin before its later words have been stored. Each word is read only when its bits are due, and by then it is already in the RAM.

A busy flag shows that work is outstanding. A sticky flag records any accept that had to be thrown away because the queue was full.

Top module: `tae_event_buffer`

## Requirements
- R1: After reset `ser_frame`, `ser_data`, `busy` and `overflow` are all 0, and the first accepted event carries event number 0.
- R2: Every clock edge stores `wr_data` in the ring. Take an accept sampled on edge t with `latency` L. Word k of its window (k = 0..WIN_WORDS-1) is the `wr_data` value sampled on edge t-L+k, provided that edge came after reset and the word has not been overwritten.
- R3: A frame keeps `ser_frame` high for exactly 4+16*WIN_WORDS consecutive cycles. Its bits on `ser_data`, in order, are 0, then 1, then the event number MSB first, then the window words from word 0 upward, each MSB first.
- R4: An accept sampled on edge t with no event active or waiting shows its first frame bit on the outputs after edge t+2.
- R5: Accepted events go out in arrival order. A waiting event's frame starts exactly 4+16*WIN_WORDS+1 cycles after the previous frame's start, so there is one low cycle of `ser_frame` between frames.
- R6: The event number is a 2-bit count of accepted events that advances by one per accepted event and wraps from 3 to 0.
- R7: An accept sampled while four accepted events are waiting to begin serialising is discarded. The event in flight does not count among the four. A discarded accept sets `overflow`, which stays set until reset, and does not advance the event number.
- R8: `busy` is 1 from the cycle after an accept until the cycle after the last bit of the last accepted event is shown. It is 0 when nothing is waiting, sending or showing.
- R9: `latency` is used only on the edge where the accept is sampled. Changing it afterwards does not change that event's window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | DATA_W | Word stored into the ring on every edge |
| l1_accept | input | 1 | Level-1 accept, one pulse per event |
| latency | input | ADDR_W | Distance of the event window start behind the write pointer |
| ser_data | output | 1 | Serial frame bit |
| ser_frame | output | 1 | High while `ser_data` carries a frame bit |
| busy | output | 1 | Events waiting, sending or still on the line |
| overflow | output | 1 | Sticky: an accept was discarded |

## Verification
Take an accept sampled on edge t, with nothing else pending. Its first frame bit is due after edge t+2 and its last after edge t+2+4+16*WIN_WORDS-1. The next frame starts 4+16*WIN_WORDS+1 edges after the previous start, and `busy` rises one edge after the accept. The bench counts posedges, drives inputs on falling edges and samples every output on the falling edge. It computes each frame's expected start edge as the later of t+2 and the previous start plus the frame length plus one. Each word is predicted arithmetically from the edge number of the write that stored it. Sweeps cover several latencies, back-to-back bursts of four, five and six accepts, and queue filling during an active frame.

// File: rtl/tae_pkg.sv
package tae_pkg;

  localparam int unsigned HDR_BITS = 4;

  typedef enum logic {SER_IDLE, SER_SEND} tae_ser_e;

  function automatic int unsigned tae_frame_len(int unsigned win_words, int unsigned word_w);
    return HDR_BITS + win_words * word_w;
  endfunction

  // marker 0,1 then event number MSB first
  function automatic logic tae_hdr_bit(logic [1:0] ev_num, logic [1:0] pos);
    case (pos)
      2'd0:    return 1'b0;
      2'd1:    return 1'b1;
      2'd2:    return ev_num[1];
      default: return ev_num[0];
    endcase
  endfunction

endpackage

// File: rtl/tae_ring.sv
module tae_ring #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wr_data,
  output logic [AW-1:0] wr_ptr,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] ring_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) wr_ptr <= '0;
    else        wr_ptr <= wr_ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    ring_mem[wr_ptr] <= wr_data;
  end

  assign rd_data = ring_mem[rd_addr];

endmodule

// File: rtl/tae_accept_q.sv
module tae_accept_q #(
  parameter int unsigned AW = 9,
  parameter int unsigned QD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_i,
  input  logic [AW-1:0] start_i,
  input  logic          pop_i,
  output logic          empty_o,
  output logic [AW-1:0] head_start_o,
  output logic [1:0]    head_idx_o,
  output logic          ovf_o
);
  localparam int unsigned QAW = (QD > 1) ? $clog2(QD) : 1;

  logic [AW-1:0]  st_mem [QD];
  logic [1:0]     ix_mem [QD];
  logic [QAW-1:0] wr_ix, rd_ix;
  logic [QAW:0]   cnt;
  logic [1:0]     ev_ctr;
  logic           full, push_ok;

  function automatic logic [QAW-1:0] q_next(logic [QAW-1:0] p);
    return (p == QAW'(QD - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == (QAW+1)'(QD));
  assign empty_o = (cnt == '0);
  assign push_ok = acc_i && !full;
  assign head_start_o = st_mem[rd_ix];
  assign head_idx_o   = ix_mem[rd_ix];

  always_ff @(posedge clk) begin
    if (push_ok) begin
      st_mem[wr_ix] <= start_i;
      ix_mem[wr_ix] <= ev_ctr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ix  <= '0;
      rd_ix  <= '0;
      cnt    <= '0;
      ev_ctr <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (push_ok) begin
        wr_ix  <= q_next(wr_ix);
        ev_ctr <= ev_ctr + 1'b1;
      end
      if (pop_i) rd_ix <= q_next(rd_ix);
      case ({push_ok, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (acc_i && full) ovf_o <= 1'b1;
    end
  end

  AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && full) |=> ovf_o); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o); // R7

endmodule

// File: rtl/tae_serializer.sv
module tae_serializer
  import tae_pkg::*;
#(
  parameter int unsigned DW  = 16,
  parameter int unsigned AW  = 9,
  parameter int unsigned WIN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          q_empty,
  input  logic [AW-1:0] q_start,
  input  logic [1:0]    q_idx,
  output logic          pop_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          active_o,
  output logic          ser_data,
  output logic          ser_frame
);
  localparam int unsigned FB = tae_frame_len(WIN, DW);
  localparam int unsigned CW = $clog2(FB + 1);
  localparam int unsigned BW = (DW > 1) ? $clog2(DW) : 1;

  tae_ser_e      state;
  logic [CW-1:0] bitcnt;
  logic [CW-1:0] doff;
  logic [AW-1:0] ev_start;
  logic [1:0]    ev_idx;
  logic [BW-1:0] bsel;
  logic          nxt_bit;
  logic [CW:0]   frm_len;

  assign active_o  = (state == SER_SEND);
  assign pop_o     = (state == SER_IDLE) && !q_empty;
  assign doff      = bitcnt - CW'(HDR_BITS);
  assign bsel      = BW'(doff % CW'(DW));
  assign rd_addr_o = ev_start + AW'(doff / CW'(DW));
  assign nxt_bit   = (bitcnt < CW'(HDR_BITS)) ? tae_hdr_bit(ev_idx, bitcnt[1:0])
                                              : rd_data_i[BW'(DW - 1) - bsel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SER_IDLE;
      bitcnt    <= '0;
      ev_start  <= '0;
      ev_idx    <= '0;
      ser_data  <= 1'b0;
      ser_frame <= 1'b0;
    end else begin
      case (state)
        SER_IDLE: begin
          ser_frame <= 1'b0;
          ser_data  <= 1'b0;
          if (!q_empty) begin
            state    <= SER_SEND;
            bitcnt   <= '0;
            ev_start <= q_start;
            ev_idx   <= q_idx;
          end
        end
        default: begin
          ser_frame <= 1'b1;
          ser_data  <= nxt_bit;
          bitcnt    <= bitcnt + 1'b1;
          if (bitcnt == CW'(FB - 1)) state <= SER_IDLE;
        end
      endcase
    end
  end

  // checker-side count of consecutive frame cycles
  always_ff @(posedge clk) begin
    if (!rst_n)         frm_len <= '0;
    else if (ser_frame) frm_len <= frm_len + 1'b1;
    else                frm_len <= '0;
  end

  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_frame && frm_len != '0) |-> (frm_len == (CW+1)'(FB))); // R3
  AST_MARK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_frame) |-> !ser_data); // R3
  AST_MARK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_frame && frm_len == (CW+1)'(1)) |-> ser_data); // R3

endmodule

// File: rtl/tae_event_buffer.sv
module tae_event_buffer #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned WIN_WORDS   = 4,
  parameter int unsigned QUEUE_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              l1_accept,
  input  logic [ADDR_W-1:0] latency,
  output logic              ser_data,
  output logic              ser_frame,
  output logic              busy,
  output logic              overflow
);
  logic [ADDR_W-1:0] wr_ptr, rd_addr, acc_start, head_start;
  logic [DATA_W-1:0] rd_data;
  logic [1:0]        head_idx;
  logic              q_empty, q_pop, ser_active;

  // frozen read pointer for an incoming accept
  assign acc_start = wr_ptr - latency;

  tae_ring #(.DW(DATA_W), .AW(ADDR_W)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_data (wr_data),
    .wr_ptr  (wr_ptr),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  tae_accept_q #(.AW(ADDR_W), .QD(QUEUE_DEPTH)) u_queue (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_i        (l1_accept),
    .start_i      (acc_start),
    .pop_i        (q_pop),
    .empty_o      (q_empty),
    .head_start_o (head_start),
    .head_idx_o   (head_idx),
    .ovf_o        (overflow)
  );

  tae_serializer #(.DW(DATA_W), .AW(ADDR_W), .WIN(WIN_WORDS)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_empty   (q_empty),
    .q_start   (head_start),
    .q_idx     (head_idx),
    .pop_o     (q_pop),
    .rd_addr_o (rd_addr),
    .rd_data_i (rd_data),
    .active_o  (ser_active),
    .ser_data  (ser_data),
    .ser_frame (ser_frame)
  );

  assign busy = ser_active || !q_empty || ser_frame;

  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    l1_accept |=> busy); // R8
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_active && q_empty) |=> !ser_frame); // R8

endmodule

// File: tb/tb_tae_event_buffer.sv
module tb_tae_event_buffer;
  localparam int DW  = 16;
  localparam int AW  = 9;
  localparam int WIN = 4;
  localparam int FB  = 4 + 16 * WIN;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          l1_accept = 1'b0;
  logic [AW-1:0] latency = '0;
  logic          ser_data, ser_frame, busy, overflow;

  tae_event_buffer #(.DATA_W(DW), .ADDR_W(AW), .WIN_WORDS(WIN), .QUEUE_DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .l1_accept(l1_accept),
    .latency(latency), .ser_data(ser_data), .ser_frame(ser_frame),
    .busy(busy), .overflow(overflow)
  );

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int edge_n   = 0;
  bit done     = 0;

  always @(posedge clk) edge_n <= edge_n + 1;

  function automatic logic [15:0] pat(int e);
    return 16'((e * 997) ^ 16'h3C5A);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // expected events
  int exp_t [256];
  int exp_l [256];
  int exp_i [256];
  int q_head = 0, q_tail = 0, ev_ctr = 0;

  task automatic record(int t, int l);
    exp_t[q_tail] = t;
    exp_l[q_tail] = l;
    exp_i[q_tail] = ev_ctr % 4;
    ev_ctr++;
    q_tail++;
  endtask

  // input data: value sampled on edge e is pat(e)
  initial forever begin
    @(negedge clk);
    wr_data = pat(edge_n + 1);
  end

  // serial monitor
  initial begin
    bit prev_f = 0;
    logic [FB-1:0] bits = '0;
    int nb = 0;
    int cur_start = 0;
    int last_start = -100000;
    forever begin
      @(negedge clk);
      if (ser_frame) begin
        if (!prev_f) begin
          cur_start = edge_n;
          nb = 0;
          if (q_head < q_tail) begin
            int es;
            es = exp_t[q_head] + 2;
            if (last_start + FB + 1 > es) es = last_start + FB + 1;
            chk(cur_start == es, "R4/R5 frame start edge", cur_start, es);
          end else chk(0, "R5 unexpected frame", cur_start, -1);
          chk(busy == 1'b1, "R8 busy during frame", busy, 1);
        end
        if (nb < FB) bits[nb] = ser_data;
        nb++;
      end else if (prev_f) begin
        chk(nb == FB, "R3 frame length", nb, FB);
        chk(bits[0] == 1'b0 && bits[1] == 1'b1, "R3 start marker", {bits[0], bits[1]}, 1);
        if (q_head < q_tail) begin
          chk({bits[2], bits[3]} == 2'(exp_i[q_head]), "R6 event number",
              {bits[2], bits[3]}, exp_i[q_head]);
          for (int k = 0; k < WIN; k++) begin
            logic [15:0] w, ew;
            for (int j = 0; j < 16; j++) w[15 - j] = bits[4 + 16 * k + j];
            ew = pat(exp_t[q_head] - exp_l[q_head] + k);
            chk(w == ew, "R2/R9 window word", w, ew);
          end
          q_head++;
        end
        last_start = cur_start;
        if (q_head == q_tail) chk(busy == 1'b0, "R8 busy after last frame", busy, 0);
        else                  chk(busy == 1'b1, "R8 busy between frames", busy, 1);
      end
      prev_f = ser_frame;
    end
  end

  task automatic burst(int n, int l, int keep);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      l1_accept = 1'b1;
      latency = AW'(l);
      if (i < keep) record(edge_n + 1, l);
    end
    @(negedge clk);
    l1_accept = 1'b0;
    latency = AW'(l + 13); // R9: later change must not matter
    chk(busy == 1'b1, "R8 busy after accept", busy, 1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    repeat (3) @(negedge clk);
    chk(q_head == q_tail, "R5 all frames received", q_head, q_tail);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ev_ctr = 0;
    @(negedge clk);
    chk(ser_frame == 1'b0, "R1 ser_frame reset", ser_frame, 0);
    chk(ser_data == 1'b0,  "R1 ser_data reset", ser_data, 0);
    chk(busy == 1'b0,      "R1 busy reset", busy, 0);
    chk(overflow == 1'b0,  "R1 overflow reset", overflow, 0);
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset();
    // single events over a latency sweep
    foreach (exp_t[i]) if (i < 7) begin
      int lats [7] = '{0, 1, 2, 3, 7, 16, 31};
      burst(1, lats[i], 1);
      wait_idle();
    end
    // back-to-back bursts
    burst(4, 5, 4);
    wait_idle();
    burst(5, 3, 5);
    wait_idle();
    chk(overflow == 1'b0, "R7 five back-to-back accepts kept", overflow, 0);
    // fill the queue during an active frame
    burst(1, 2, 1);
    repeat (8) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      burst(1, 6 + i, 1);
      repeat (2) @(negedge clk);
    end
    chk(overflow == 1'b0, "R7 four waiting accepts kept", overflow, 0);
    burst(1, 4, 0);
    chk(overflow == 1'b1, "R7 fifth waiting accept dropped", overflow, 1);
    wait_idle();
    chk(overflow == 1'b1, "R7 overflow sticky", overflow, 1);
    // reset again: numbering restarts, six back-to-back drop the sixth
    do_reset();
    burst(6, 9, 5);
    wait_idle();
    chk(overflow == 1'b1, "R7 sixth back-to-back accept dropped", overflow, 1);
    done = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", edge_n, 0);
      summary();
    end
  end

endmodule